// File: doc/BRIEF.md
# RS-485 Half-Duplex Transmit Direction Controller

This block serialises bytes onto a two-wire half-duplex RS-485 bus and runs the transceiver's direction lines on its own. Software only hands over bytes. The block switches the line driver on and holds the line at a driven idle 1 for a settling window. It then sends each character: a start bit, eight data bits with the LSB first, an optional even-parity bit and a selectable stop length. The driver stays on until the last stop bit has fully left the line and a programmable hold window has run out. Only then does it release the bus, so that another node can answer. It does not drop the driver on a buffer-empty condition, which comes one bit or one frame too early.

Bytes arrive on a valid/ready stream that has a one-entry holding register behind it. `wr_ready` is high exactly when that register is empty. A byte is taken on a clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the source must hold `wr_valid` and `wr_data` steady. Bytes that are queued before the current character ends go out back to back, without a new settling window. All window lengths are counted in half-bit periods of the programmed divisor, so they follow any bit-rate change without a separate setting.

A second mode suits buses with fail-safe biasing. In that mode the driver data stays at 0 and the driver enable carries the inverted serial bit. A 0 bit actively pulls the bus, and a 1 bit lets the bias return it to idle. This mode has no settling window and no hold window. The configuration inputs must stay stable while `tx_busy` is high.

Top module: `rs485_tx_ctrl`

## Requirements
- R1: `wr_ready` is high exactly when the holding register is empty. A byte is accepted on an edge where `wr_valid` and `wr_ready` are both high. The holding register then stays full, with its content unchanged, until that byte is moved into the shifter.
- R2: A character is sent in this order: one start bit at 0, then data bits 0 to 7, then an even-parity bit (the XOR of the data) when `parity_en`=1, then stop bits at 1. `stop_sel` sets the stop length: 0 gives 1 bit, 1 gives 1.5 bits, and 2 or 3 give 2 bits.
- R3: One half-bit lasts `baud_div` clock cycles, and a `baud_div` of 0 is treated as 1. A bit lasts two half-bits.
- R4: In driven mode, `drv_en` rises with `line_d`=1. The start bit follows after G half-bits, where G = ceil(GUARD_HC·F/2) and F is the character length in half-bits (2·(9+parity_en) plus the stop half-bits).
- R5: `drv_en` stays high through the whole final stop bit. `shift_done` pulses for one cycle in the first cycle after the last stop half-bit ends.
- R6: In driven mode, once a character is complete and no byte is queued, the block holds `drv_en`=1 and `line_d`=1 for H = ceil(`hold_hc`·F/2) half-bits and then releases the driver. With `hold_hc`=0 it releases immediately. A value of 3 gives 1.5 character times.
- R7: A byte queued before a character ends starts at the very next half-bit, with no settling or hold window in between. A byte accepted during the hold window starts at the next half-bit boundary, and the driver stays enabled throughout.
- R8: `tx_busy` goes high in the cycle after a byte is accepted and falls together with `drv_en` at release. `tx_done` is a one-cycle pulse in the first cycle in which `drv_en` is low after a transmission.
- R9: In driven mode, `rcv_en` is low while `drv_en` is high unless `echo_en`=1. At all other times `rcv_en` is high.
- R10: With `dom_mode`=1, `line_d` is 0 at all times. `drv_en` equals the inverted serial bit while a character is sent and is 0 otherwise. `rcv_en` stays 1, and no settling or hold window is inserted.
- R11: After reset, and between transmissions, `drv_en`=0, `tx_busy`=0 and `wr_ready`=1. In that state `line_d` is 1 in driven mode and 0 in `dom_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Byte offered on `wr_data` |
| wr_ready | output | 1 | Holding register empty, byte can be taken |
| wr_data | input | 8 | Byte to transmit |
| baud_div | input | DIV_W | Clock cycles per half-bit (0 acts as 1) |
| parity_en | input | 1 | Append even-parity bit |
| stop_sel | input | 2 | Stop length: 0 = 1, 1 = 1.5, 2/3 = 2 bits |
| hold_hc | input | HOLD_W | Post-frame hold in half-character units |
| dom_mode | input | 1 | Dominant/recessive mode select |
| echo_en | input | 1 | Keep receiver enabled while driving |
| line_d | output | 1 | Transceiver driver data |
| drv_en | output | 1 | Transceiver driver enable |
| rcv_en | output | 1 | Transceiver receiver enable (active high) |
| tx_busy | output | 1 | Byte pending or bus held by this node |
| tx_done | output | 1 | One-cycle pulse at driver release |
| shift_done | output | 1 | One-cycle pulse after a character's final stop half-bit |

## Verification
A half-bit counter that is off by one shows up as a stretched or shortened segment of `drv_en`/`line_d`. This happens within one character, so the bench compares every cycle from the rise of `drv_en` to `tx_done` against a waveform it builds itself. A sequencer that leaves the hold window too early makes `drv_en` fall before the programmed hold time has run. A sequencer that inserts a settling window between queued bytes makes the second start bit arrive late, so both faults alter the length of the waveform. A holding flag that never clears or never sets leaves `wr_ready` or `tx_busy` wrong in the cycle right after a write, and it causes either a lost byte or a repeated byte in the next character.

// File: rtl/rs485_tx_pkg.sv
package rs485_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GUARD = 2'd1,
    ST_FRAME = 2'd2,
    ST_HOLD  = 2'd3
  } seq_state_t;

  localparam int MAX_FRAME_HALVES = 24;

  // stop length in half-bit units
  function automatic logic [2:0] stop_halves(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd2;
      2'd1:    return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  // whole character length in half-bit units
  function automatic logic [4:0] frame_halves(input logic par_en, input logic [1:0] sel);
    return 5'd18 + (par_en ? 5'd2 : 5'd0) + {2'b00, stop_halves(sel)};
  endfunction

endpackage

// File: rtl/rs485_half_timer.sv
module rs485_half_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = (div == '0) ? DIV_W'(1) : div;
  assign tick    = run && (cnt == div_eff - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + DIV_W'(1);
  end

  // R3
  tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
endmodule

// File: rtl/rs485_frame_shift.sv
module rs485_frame_shift
  import rs485_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] data,
  input  logic       parity_en,
  input  logic [1:0] stop_sel,
  input  logic       tick,
  output logic       bit_o,
  output logic       end_o,
  output logic       active_o
);
  logic [9:0] sreg;
  logic [4:0] left;
  logic       phase;

  assign bit_o = active_o ? sreg[0] : 1'b1;
  assign end_o = active_o && tick && (left == 5'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg     <= '1;
      left     <= '0;
      phase    <= 1'b0;
      active_o <= 1'b0;
    end else if (load) begin
      // parity slot reads 1 when parity is off, blending into the stop run
      sreg     <= {parity_en ? ^data : 1'b1, data, 1'b0};
      left     <= frame_halves(parity_en, stop_sel);
      phase    <= 1'b0;
      active_o <= 1'b1;
    end else if (active_o && tick) begin
      left  <= left - 5'd1;
      phase <= ~phase;
      if (phase) sreg <= {1'b1, sreg[9:1]};
      if (left == 5'd1) active_o <= 1'b0;
    end
  end

  // R5
  last_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |-> bit_o);
  // R7
  no_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!active_o || end_o));
endmodule

// File: rtl/rs485_dir_seq.sv
module rs485_dir_seq
  import rs485_tx_pkg::*;
#(
  parameter int HOLD_W   = 4,
  parameter int GUARD_HC = 3,
  parameter int HW       = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic              frame_end,
  input  logic              dom_mode,
  input  logic              parity_en,
  input  logic [1:0]        stop_sel,
  input  logic [HOLD_W-1:0] hold_hc,
  output seq_state_t        state,
  output logic              load,
  output logic              run,
  output logic              tx_done,
  output logic              shift_done
);
  seq_state_t     nxt;
  logic [HW-1:0]  hcnt, hn;
  logic [HW-1:0]  f_h, g_h, h_h;

  always_comb begin
    f_h = HW'(frame_halves(parity_en, stop_sel));
    g_h = HW'((GUARD_HC * int'(f_h) + 1) / 2);
    h_h = HW'((int'(hold_hc) * int'(f_h) + 1) / 2);
  end

  assign run = (state != ST_IDLE);

  always_comb begin
    nxt  = state;
    hn   = hcnt;
    load = 1'b0;
    case (state)
      ST_IDLE: if (hold_full) begin
        hn = '0;
        if (dom_mode) begin
          load = 1'b1;
          nxt  = ST_FRAME;
        end else begin
          nxt = ST_GUARD;
        end
      end
      ST_GUARD: if (tick) begin
        if (hcnt == g_h - HW'(1)) begin
          load = 1'b1;
          nxt  = ST_FRAME;
        end else begin
          hn = hcnt + HW'(1);
        end
      end
      ST_FRAME: if (frame_end) begin
        if (hold_full) begin
          load = 1'b1;
        end else if (dom_mode || h_h == '0) begin
          nxt = ST_IDLE;
        end else begin
          nxt = ST_HOLD;
          hn  = '0;
        end
      end
      ST_HOLD: if (tick) begin
        if (hold_full) begin
          load = 1'b1;
          nxt  = ST_FRAME;
        end else if (hcnt == h_h - HW'(1)) begin
          nxt = ST_IDLE;
        end else begin
          hn = hcnt + HW'(1);
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      hcnt       <= '0;
      tx_done    <= 1'b0;
      shift_done <= 1'b0;
    end else begin
      state      <= nxt;
      hcnt       <= hn;
      tx_done    <= (state != ST_IDLE) && (nxt == ST_IDLE);
      shift_done <= frame_end;
    end
  end

  // R4
  guard_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GUARD) |-> !dom_mode);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (state == ST_IDLE));
  // R6
  hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && nxt == ST_IDLE) |-> tick);
endmodule

// File: rtl/rs485_tx_ctrl.sv
module rs485_tx_ctrl
  import rs485_tx_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int HOLD_W   = 4,
  parameter int GUARD_HC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              parity_en,
  input  logic [1:0]        stop_sel,
  input  logic [HOLD_W-1:0] hold_hc,
  input  logic              dom_mode,
  input  logic              echo_en,
  output logic              line_d,
  output logic              drv_en,
  output logic              rcv_en,
  output logic              tx_busy,
  output logic              tx_done,
  output logic              shift_done
);
  localparam int HW = $clog2(((1 << HOLD_W) + GUARD_HC) * MAX_FRAME_HALVES) + 1;

  logic       hold_full;
  logic [7:0] hold_q;
  logic       accept, load, tick, run;
  logic       frame_bit, frame_end, frame_act;
  seq_state_t state;

  assign wr_ready = !hold_full;
  assign accept   = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else if (accept) begin
      hold_full <= 1'b1;
      hold_q    <= wr_data;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  rs485_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .div(baud_div), .tick(tick)
  );

  rs485_frame_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .data(hold_q),
    .parity_en(parity_en), .stop_sel(stop_sel), .tick(tick),
    .bit_o(frame_bit), .end_o(frame_end), .active_o(frame_act)
  );

  rs485_dir_seq #(.HOLD_W(HOLD_W), .GUARD_HC(GUARD_HC), .HW(HW)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hold_full(hold_full),
    .frame_end(frame_end), .dom_mode(dom_mode), .parity_en(parity_en),
    .stop_sel(stop_sel), .hold_hc(hold_hc), .state(state), .load(load),
    .run(run), .tx_done(tx_done), .shift_done(shift_done)
  );

  always_comb begin
    if (dom_mode) begin
      line_d = 1'b0;
      drv_en = (state == ST_FRAME) && !frame_bit;
      rcv_en = 1'b1;
    end else begin
      line_d = (state == ST_FRAME) ? frame_bit : 1'b1;
      drv_en = (state != ST_IDLE);
      rcv_en = echo_en || (state == ST_IDLE);
    end
  end

  assign tx_busy = hold_full || (state != ST_IDLE);

  // R1
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !load) |=> (hold_full && $stable(hold_q)));
  // R11
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dom_mode && !drv_en) |-> line_d);
  // R9
  rcv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && !echo_en && !dom_mode) |-> !rcv_en);
  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !drv_en);
  // R10
  dom_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dom_mode |-> (!line_d && rcv_en));
  // R2
  frame_in_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_act |-> (state == ST_FRAME));
endmodule

// File: tb/sim_rs485_tx_ctrl.sv
`timescale 1ns/1ps
module sim_rs485_tx_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_data = '0;
  logic [15:0] baud_div = 16'd1;
  logic        parity_en = 1'b0;
  logic [1:0]  stop_sel = 2'd0;
  logic [3:0]  hold_hc = 4'd3;
  logic        dom_mode = 1'b0;
  logic        echo_en = 1'b0;
  logic        line_d, drv_en, rcv_en, tx_busy, tx_done, shift_done;

  always #10 clk = ~clk;

  rs485_tx_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .baud_div(baud_div), .parity_en(parity_en),
    .stop_sel(stop_sel), .hold_hc(hold_hc), .dom_mode(dom_mode),
    .echo_en(echo_en), .line_d(line_d), .drv_en(drv_en), .rcv_en(rcv_en),
    .tx_busy(tx_busy), .tx_done(tx_done), .shift_done(shift_done)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [4:0] cap [0:4095];
  logic [4:0] expv [0:4095];
  int cap_n, exp_n;
  logic sd_pend;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int fhalves(input int par, input int stp);
    return 2 * (9 + par) + ((stp == 0) ? 2 : (stp == 1) ? 3 : 4);
  endfunction

  function automatic logic fbit(input logic [7:0] b, input int i);
    if (i == 0) return 1'b0;
    if (i <= 8) return b[i-1];
    return ^b;
  endfunction

  task automatic add(input logic [3:0] v, input int cycles);
    for (int k = 0; k < cycles; k++) begin
      expv[exp_n] = {v, sd_pend};
      sd_pend = 1'b0;
      exp_n++;
    end
  endtask

  // expected {drv,line,rcv,busy,sdone} per cycle from drv_en rise to tx_done
  task automatic build_exp(input int n, input logic [7:0] b0, input logic [7:0] b1,
                           input int par, input int stp, input int hc,
                           input bit dom, input bit echo, input int dv);
    int dve, f;
    dve = (dv == 0) ? 1 : dv;
    f = fhalves(par, stp);
    exp_n = 0;
    sd_pend = 1'b0;
    if (!dom) add({1'b1, 1'b1, echo, 1'b1}, ((3 * f + 1) / 2) * dve);
    for (int fr = 0; fr < n; fr++) begin
      logic [7:0] b;
      b = (fr == 0) ? b0 : b1;
      for (int i = 0; i < 9 + par; i++) begin
        logic v;
        v = fbit(b, i);
        if (dom) add({~v, 1'b0, 1'b1, 1'b1}, 2 * dve);
        else     add({1'b1, v, echo, 1'b1}, 2 * dve);
      end
      if (dom) add({1'b0, 1'b0, 1'b1, 1'b1}, (f - 2 * (9 + par)) * dve);
      else     add({1'b1, 1'b1, echo, 1'b1}, (f - 2 * (9 + par)) * dve);
      sd_pend = 1'b1;
    end
    if (!dom) add({1'b1, 1'b1, echo, 1'b1}, ((hc * f + 1) / 2) * dve);
    add({1'b0, ~dom, 1'b1, 1'b0}, 1);
  endtask

  task automatic push(input logic [7:0] b);
    wr_data  = b;
    wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic capture();
    bit done;
    while (!drv_en) @(negedge clk);
    cap_n = 0;
    done = 1'b0;
    while (!done) begin
      cap[cap_n] = {drv_en, line_d, rcv_en, tx_busy, shift_done};
      cap_n++;
      done = tx_done;
      @(negedge clk);
    end
  endtask

  task automatic run_txn(input int n, input logic [7:0] b0, input logic [7:0] b1,
                         input int par, input int stp, input int hc,
                         input bit dom, input bit echo, input int dv, input string req);
    int bad;
    baud_div  = 16'(dv);
    parity_en = par[0];
    stop_sel  = 2'(stp);
    hold_hc   = 4'(hc);
    dom_mode  = dom;
    echo_en   = echo;
    @(negedge clk);
    build_exp(n, b0, b1, par, stp, hc, dom, echo, dv);
    fork
      begin
        push(b0);
        // R1 R8: holding register full right after the write
        chk(!wr_ready && tx_busy, "R1 R8", "ready low / busy high after write",
            int'({wr_ready, tx_busy}), 1);
        if (n > 1) push(b1);
      end
      capture();
    join
    chk(cap_n == exp_n, req, "frame length in cycles", cap_n, exp_n);
    bad = -1;
    for (int i = 0; i < cap_n && i < exp_n; i++)
      if (bad < 0 && cap[i] !== expv[i]) bad = i;
    chk(bad < 0, req, $sformatf("waveform {drv,line,rcv,busy,sdone} at cycle %0d", bad),
        (bad < 0) ? 0 : int'(cap[bad]), (bad < 0) ? 0 : int'(expv[bad]));
    // R11: idle state after release
    chk(!drv_en && (line_d == !dom) && wr_ready && !tx_busy && !tx_done, "R11",
        "idle {drv,line,ready,busy}", int'({drv_en, line_d, wr_ready, tx_busy}),
        int'({1'b0, ~dom, 1'b1, 1'b0}));
  endtask

  // R7: byte arriving inside the hold window
  task automatic refill_test();
    int f, g, h, dv, s2, lowdrv;
    dv = 2; f = fhalves(0, 0); g = (3 * f + 1) / 2; h = (8 * f + 1) / 2;
    baud_div = 16'(dv); parity_en = 1'b0; stop_sel = 2'd0; hold_hc = 4'd8;
    dom_mode = 1'b0; echo_en = 1'b0;
    @(negedge clk);
    fork
      begin
        push(8'hFF);
        while (!shift_done) @(negedge clk);
        repeat (3) @(negedge clk);
        push(8'hFF);
      end
      capture();
    join
    s2 = -1; lowdrv = 0;
    for (int i = 0; i < cap_n; i++) begin
      if (i < cap_n - 1 && !cap[i][4]) lowdrv++;
      if (s2 < 0 && i > (g + f) * dv && !cap[i][3]) s2 = i;
    end
    chk(lowdrv == 0, "R7", "driver drops before release", lowdrv, 0);
    chk(s2 > 0 && ((s2 - (g + f) * dv) % dv) == 0 && (s2 - (g + f) * dv) < h * dv,
        "R7", "refill start offset into hold", s2 - (g + f) * dv, dv);
    chk(cap_n - s2 == (f + h) * dv + 1, "R6 R7", "cycles from second start to release",
        cap_n - s2, (f + h) * dv + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(wr_ready && !drv_en && line_d && !tx_busy && rcv_en && !tx_done && !shift_done,
        "R11", "reset outputs", int'({wr_ready, drv_en, line_d, tx_busy, rcv_en}), 5'b10101);

    // R2 R3 R4 R5 R6: 8 data, even parity, 1 stop, 1.5 char hold
    run_txn(1, 8'hA5, 8'h00, 1, 0, 3, 0, 0, 2, "R2 R3 R4 R5 R6");
    // R2: 1.5 stop bits with parity
    run_txn(1, 8'h3C, 8'h00, 1, 1, 3, 0, 0, 1, "R2 R5");
    // R6: zero hold, 2 stop bits
    run_txn(1, 8'h81, 8'h00, 0, 2, 0, 0, 0, 3, "R6 R5");
    // R3: divisor 0 acts as 1
    run_txn(1, 8'h5A, 8'h00, 0, 0, 1, 0, 0, 0, "R3");
    // R7 R9: back to back with echo enabled
    run_txn(2, 8'h0F, 8'hF0, 1, 0, 2, 0, 1, 2, "R7 R9");
    // R10: dominant mode, all zeros then pattern
    run_txn(2, 8'h00, 8'h55, 0, 0, 3, 1, 0, 2, "R10");
    run_txn(1, 8'hFF, 8'h00, 1, 2, 5, 1, 1, 1, "R10");
    // R6: longest hold
    run_txn(1, 8'hC3, 8'h00, 0, 0, 15, 0, 0, 1, "R6");
    refill_test();

    for (int t = 0; t < 30; t++) begin
      int n, par, stp, hc, dv;
      bit dom, echo;
      n = 1 + ($urandom % 2); par = $urandom % 2; stp = $urandom % 3;
      hc = $urandom % 6; dv = 1 + ($urandom % 3);
      dom = ($urandom % 4) == 0; echo = $urandom % 2;
      run_txn(n, 8'($urandom), 8'($urandom), par, stp, hc, dom, echo, dv,
              dom ? "R10 R7" : "R2 R3 R4 R5 R6 R7 R9");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule